// File: doc/BRIEF.md
# Byte-Port Packet Interface

This block is the device side of a small register-mapped network adapter. A host processor reaches it over a 32-bit register bus with separate read and write strobes. Every packet passes through single-byte data ports. A received packet is first buffered in full. Its length is then shown in a count register, and the host drains the bytes one port read at a time. To transmit, the host programs a length and writes that many bytes into a transmit port. The block then forwards the packet on a byte stream with valid, ready and last signals.

The register bus has no wait states. Read data is driven combinationally while `bus_rd` is high, and any side effect of the access, such as advancing the receive port, takes place at the clock edge that ends the access. The interrupt control register is kept by a separate block: the `rx_avail` and `tx_done` pulses feed that block, and its receive-pending status comes back in on `rx_hold`. Both buffers have a depth set by a parameter. Counts are 17 bits wide, so lengths up to 65536 bytes can be expressed.

Top module: `byteport_nic`

## Requirements
- R1: After reset, the busy, receive-count and transmit-count registers all read 0, `rx_ready` is 1, and `tx_valid` and `tx_done` are 0.
- R2: The identity register reads as eight ASCII characters "PKTPORT" followed by the version digit. The first character sits in bits 7:0, and each following character occupies the next higher byte. Word 0x00 returns the low 32 bits and word 0x04 returns the high 32 bits.
- R3: Word 0x18 reads the parameter IRQ_LINE. Word 0x14 reads 0. Writes to the identity, busy, receive-count and line-index words have no effect.
- R4: When the last byte of an incoming packet is accepted, the receive count at 0x0C holds the packet length from the next cycle on, and `rx_avail` is high for exactly that one cycle.
- R5: Each read of the receive port at 0x1C returns the next buffered byte in arrival order in bits 7:0, with bits 31:8 at zero, and lowers the receive count by one.
- R6: A read of the receive port while the receive count is 0 returns 0 and leaves the count at 0.
- R7: `rx_ready` is 0 while the receive count is nonzero. A new packet is not taken in while `rx_hold` is 1, but a packet whose first byte has already been accepted completes.
- R8: A write to the transmit count at 0x10 takes effect only when the count is 0 and no packet is being sent. Values above DEPTH are stored as DEPTH. The register reads back the stored value.
- R9: Writes to the transmit port at 0x20 store bits 7:0 only. The write that supplies the last byte of the programmed count clears the transmit count to 0. Port writes while the count is 0 are ignored and produce no output.
- R10: The buffered packet is sent on `tx_data` in write order, with `tx_last` set on the final byte only. While `tx_valid` is 1 and `tx_ready` is 0, the byte and the last flag hold still.
- R11: `tx_done` is high for exactly one cycle, starting in the cycle after the final byte is handed over.
- R12: Busy at 0x08 (bit 0) is 1 in any of these cases: a receive is partly loaded, buffered receive bytes remain, the transmit count is nonzero, or a packet is being sent. It is 0 otherwise.
- R13: An incoming packet longer than DEPTH is cut to its first DEPTH bytes, and the receive count reports DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address; bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the packet |
| rx_ready | output | 1 | Block accepts an incoming byte |
| rx_hold | input | 1 | Receive-pending status from the interrupt block |
| rx_avail | output | 1 | One-cycle pulse: a received packet is ready to read |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the packet |
| tx_ready | input | 1 | Sink accepts the outgoing byte |
| tx_done | output | 1 | One-cycle pulse: packet fully handed over |

## Verification
The hardest state to reach from the ports is a transmit count write that arrives while a packet is still draining. The count has already returned to zero by then, so the write looks legal. To get there, the bench slows the sink by toggling `tx_ready` every cycle, which stretches the send window, and issues the count write inside that window. The second hard state is a held receive: the bench raises `rx_hold` before it presents a byte, then confirms through the count register and `rx_ready` that nothing was taken in before it releases the hold.

// File: rtl/byteport_pkg.sv
package byteport_pkg;

  // Word indices (byte address bits 5:2)
  localparam logic [3:0] W_ID_LO   = 4'd0;
  localparam logic [3:0] W_ID_HI   = 4'd1;
  localparam logic [3:0] W_BUSY    = 4'd2;
  localparam logic [3:0] W_RXCNT   = 4'd3;
  localparam logic [3:0] W_TXCNT   = 4'd4;
  localparam logic [3:0] W_IRQCTL  = 4'd5;
  localparam logic [3:0] W_IRQLINE = 4'd6;
  localparam logic [3:0] W_RXPORT  = 4'd7;
  localparam logic [3:0] W_TXPORT  = 4'd8;

  // Identity: seven name characters then a version digit, first char in the low byte
  function automatic logic [63:0] make_id(input int unsigned ver);
    logic [63:0] id;
    id = '0;
    id[7:0]   = 8'h50; // P
    id[15:8]  = 8'h4B; // K
    id[23:16] = 8'h54; // T
    id[31:24] = 8'h50; // P
    id[39:32] = 8'h4F; // O
    id[47:40] = 8'h52; // R
    id[55:48] = 8'h54; // T
    id[63:56] = 8'h30 + 8'(ver % 10);
    return id;
  endfunction

  // Limit a requested length to a buffer depth
  function automatic logic [31:0] clamp_len(input logic [31:0] req, input int unsigned lim);
    return (req > 32'(lim)) ? 32'(lim) : req;
  endfunction

  // Length after one more byte, saturating at the depth
  function automatic logic [31:0] grow_len(input logic [31:0] cur, input int unsigned lim);
    return (cur >= 32'(lim)) ? 32'(lim) : cur + 32'd1;
  endfunction

endpackage

// File: rtl/byteport_rx_buf.sv
module byteport_rx_buf
  import byteport_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             hold,
  input  logic             pop,
  output logic [7:0]       pop_data,
  output logic [CNT_W-1:0] count,
  output logic             loading,
  output logic             avail
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wlen;
  logic [CNT_W-1:0] rptr;
  logic             accept;
  logic             pop_ok;
  logic             have;

  assign have     = (count != '0);
  assign in_ready = !have && (loading || !hold);
  assign accept   = in_valid && in_ready;
  assign pop_ok   = pop && have;
  assign pop_data = have ? mem[rptr[IDX_W-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (accept && (wlen < DEPTH_C))
      mem[wlen[IDX_W-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlen    <= '0;
      rptr    <= '0;
      count   <= '0;
      loading <= 1'b0;
      avail   <= 1'b0;
    end else begin
      avail <= 1'b0;
      if (accept) begin
        if (in_last) begin
          count   <= CNT_W'(grow_len(32'(wlen), DEPTH));
          wlen    <= '0;
          rptr    <= '0;
          loading <= 1'b0;
          avail   <= 1'b1;
        end else begin
          wlen    <= CNT_W'(grow_len(32'(wlen), DEPTH));
          loading <= 1'b1;
        end
      end else if (pop_ok) begin
        count <= count - 1'b1;
        rptr  <= rptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/byteport_tx_buf.sv
module byteport_tx_buf
  import byteport_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [31:0]      cnt_wdata,
  input  logic             dat_wr,
  input  logic [7:0]       dat_wdata,
  output logic [CNT_W-1:0] count,
  output logic             sending,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  output logic             done
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wptr;
  logic [CNT_W-1:0] rptr;
  logic [CNT_W-1:0] len;
  logic             cnt_ok;
  logic             dat_ok;
  logic             fill_end;
  logic             fire;
  logic             at_end;

  assign cnt_ok    = cnt_wr && (count == '0) && !sending;
  assign dat_ok    = dat_wr && (count != '0);
  assign fill_end  = dat_ok && ((wptr + 1'b1) == count);
  assign at_end    = (rptr + 1'b1) == len;
  assign out_valid = sending;
  assign out_data  = mem[rptr[IDX_W-1:0]];
  assign out_last  = sending && at_end;
  assign fire      = sending && out_ready;

  always_ff @(posedge clk) begin
    if (dat_ok)
      mem[wptr[IDX_W-1:0]] <= dat_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      wptr    <= '0;
      rptr    <= '0;
      len     <= '0;
      sending <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cnt_ok) begin
        count <= CNT_W'(clamp_len(cnt_wdata, DEPTH));
        wptr  <= '0;
      end else if (fill_end) begin
        len     <= count;
        count   <= '0;
        rptr    <= '0;
        sending <= 1'b1;
      end else if (dat_ok) begin
        wptr <= wptr + 1'b1;
      end
      if (fire) begin
        if (at_end) begin
          sending <= 1'b0;
          done    <= 1'b1;
        end else begin
          rptr <= rptr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/byteport_regs.sv
module byteport_regs
  import byteport_pkg::*;
#(
  parameter int IRQ_LINE = 5,
  parameter int VERSION  = 1,
  parameter int CNT_W    = 17
) (
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [5:0]       bus_addr,
  output logic [31:0]      bus_rdata,
  input  logic             busy,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [7:0]       rx_byte,
  output logic             rx_pop,
  output logic             tx_cnt_wr,
  output logic             tx_dat_wr
);
  localparam logic [63:0] ID_VAL = make_id(VERSION);

  logic [3:0] word;
  assign word = bus_addr[5:2];

  assign rx_pop    = bus_rd && (word == W_RXPORT);
  assign tx_cnt_wr = bus_wr && (word == W_TXCNT);
  assign tx_dat_wr = bus_wr && (word == W_TXPORT);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (word)
        W_ID_LO:   bus_rdata = ID_VAL[31:0];
        W_ID_HI:   bus_rdata = ID_VAL[63:32];
        W_BUSY:    bus_rdata = {31'd0, busy};
        W_RXCNT:   bus_rdata = 32'(rx_count);
        W_TXCNT:   bus_rdata = 32'(tx_count);
        W_IRQLINE: bus_rdata = 32'(IRQ_LINE);
        W_RXPORT:  bus_rdata = {24'd0, rx_byte};
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/byteport_nic.sv
module byteport_nic #(
  parameter int DEPTH    = 64,
  parameter int IRQ_LINE = 5,
  parameter int VERSION  = 1,
  parameter int MAX_PKT  = 65536,
  localparam int CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  input  logic        rx_hold,
  output logic        rx_avail,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        tx_done
);
  logic [CNT_W-1:0] rx_count;
  logic [CNT_W-1:0] tx_count;
  logic [7:0]       rx_byte;
  logic             rx_loading;
  logic             rx_pop;
  logic             tx_cnt_wr;
  logic             tx_dat_wr;
  logic             tx_sending;
  logic             busy;

  assign busy = rx_loading || (rx_count != '0) || (tx_count != '0) || tx_sending;

  byteport_regs #(.IRQ_LINE(IRQ_LINE), .VERSION(VERSION), .CNT_W(CNT_W)) u_regs (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .busy(busy), .rx_count(rx_count), .tx_count(tx_count), .rx_byte(rx_byte),
    .rx_pop(rx_pop), .tx_cnt_wr(tx_cnt_wr), .tx_dat_wr(tx_dat_wr)
  );

  byteport_rx_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
    .in_last(rx_last), .in_ready(rx_ready), .hold(rx_hold), .pop(rx_pop),
    .pop_data(rx_byte), .count(rx_count), .loading(rx_loading), .avail(rx_avail)
  );

  byteport_tx_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cnt_wr(tx_cnt_wr), .cnt_wdata(bus_wdata),
    .dat_wr(tx_dat_wr), .dat_wdata(bus_wdata[7:0]), .count(tx_count),
    .sending(tx_sending), .out_valid(tx_valid), .out_data(tx_data),
    .out_last(tx_last), .out_ready(tx_ready), .done(tx_done)
  );

endmodule

// File: rtl/byteport_nic_chk.sv
module byteport_nic_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_last,
  input logic             rx_ready,
  input logic             rx_avail,
  input logic             rx_pop,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             tx_ready,
  input logic             tx_done,
  input logic             busy
);
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R11
  tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(tx_valid && tx_ready && tx_last));

  // R5
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && (rx_count != '0) |=> rx_count == $past(rx_count) - CNT_W'(1));

  // R6
  rx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && (rx_count == '0) && !(rx_valid && rx_ready && rx_last) |=> rx_count == '0);

  // R7
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_count == '0);

  // R4
  rx_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail |-> rx_count != '0);

  // R8
  tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CNT_W'(DEPTH));

  // R12
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid || (rx_count != '0) |-> busy);

endmodule

bind byteport_nic byteport_nic_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
  .rx_ready(rx_ready), .rx_avail(rx_avail), .rx_pop(rx_pop),
  .rx_count(rx_count), .tx_count(tx_count), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
  .tx_done(tx_done), .busy(busy)
);

// File: tb/test_byteport_nic.sv
`timescale 1ns/1ps
module test_byteport_nic;
  localparam int DEPTH = 16;
  localparam logic [5:0] A_IDLO = 6'h00, A_IDHI = 6'h04, A_BUSY = 6'h08,
                         A_RXCNT = 6'h0C, A_TXCNT = 6'h10, A_IRQCTL = 6'h14,
                         A_LINE = 6'h18, A_RXP = 6'h1C, A_TXP = 6'h20;

  logic clk = 0, rst_n = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rx_valid = 0, rx_last = 0, rx_hold = 0, rx_ready, rx_avail;
  logic [7:0] rx_data = 0;
  logic tx_valid, tx_last, tx_ready = 1, tx_done;
  logic [7:0] tx_data;

  int n_chk = 0, n_fail = 0;
  int avail_n = 0, done_n = 0, txn = 0;
  logic [7:0] txq [64];
  logic       txl [64];
  logic bp_mode = 0;
  logic finished = 0;

  always #2.5 clk = ~clk;

  byteport_nic #(.DEPTH(DEPTH), .IRQ_LINE(5), .VERSION(1)) i_byteport_nic (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready), .rx_hold(rx_hold),
    .rx_avail(rx_avail), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_done(tx_done)
  );

  // Monitors sample just after the falling edge
  always begin
    @(negedge clk); #1;
    if (rx_avail) avail_n++;
    if (tx_done) done_n++;
    if (tx_valid && tx_ready && txn < 64) begin
      txq[txn] = tx_data; txl[txn] = tx_last; txn++;
    end
  end

  always @(negedge clk) if (bp_mode) tx_ready = ~tx_ready;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'(base + 3 * i);
  endfunction

  task automatic send_rx(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = pat(base, i); rx_last = (i == len - 1);
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic drain_rx(input int cnt, input int base, input string req);
    logic [31:0] v;
    for (int i = 0; i < cnt; i++) begin
      rd(A_RXP, v); chk(req, v, {24'd0, pat(base, i)});
      rd(A_RXCNT, v); chk(req, v, 32'(cnt - i - 1));
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_BUSY, v);  chk("R1 busy", v, 0);
    rd(A_RXCNT, v); chk("R1 rxcnt", v, 0);
    rd(A_TXCNT, v); chk("R1 txcnt", v, 0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 1);
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);
    chk("R1 tx_done", {31'd0, tx_done}, 0);
  endtask

  task automatic t_ident;
    logic [31:0] v;
    logic [63:0] exp;
    string s = "PKTPORT1";
    for (int i = 0; i < 8; i++) exp[8*i +: 8] = s[i];
    rd(A_IDLO, v); chk("R2 id low", v, exp[31:0]);
    rd(A_IDHI, v); chk("R2 id high", v, exp[63:32]);
    rd(A_LINE, v); chk("R3 line", v, 5);
    rd(A_IRQCTL, v); chk("R3 intctl", v, 0);
    wr(A_LINE, 32'hFF); wr(A_RXCNT, 32'h33); wr(A_BUSY, 1); wr(A_IDLO, 0);
    rd(A_LINE, v); chk("R3 line after write", v, 5);
    rd(A_RXCNT, v); chk("R3 rxcnt after write", v, 0);
    rd(A_BUSY, v); chk("R3 busy after write", v, 0);
    rd(A_IDLO, v); chk("R3 id after write", v, exp[31:0]);
  endtask

  task automatic t_rx_basic;
    logic [31:0] v;
    int a0 = avail_n;
    send_rx(5, 8'h10);
    rd(A_RXCNT, v); chk("R4 rxcnt", v, 5);
    chk("R4 avail once", 32'(avail_n - a0), 1);
    rd(A_BUSY, v); chk("R12 busy rx", v, 1);
    chk("R7 ready low", {31'd0, rx_ready}, 0);
    drain_rx(5, 8'h10, "R5 drain");
    rd(A_RXP, v); chk("R6 empty read", v, 0);
    rd(A_RXCNT, v); chk("R6 count stays", v, 0);
    rd(A_BUSY, v); chk("R12 busy idle", v, 0);
  endtask

  task automatic t_rx_hold;
    logic [31:0] v;
    @(negedge clk); rx_hold = 1; rx_valid = 1; rx_data = 8'hEE; rx_last = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R7 hold blocks", {31'd0, rx_ready}, 0);
    end
    rx_valid = 0; rx_last = 0;
    rd(A_RXCNT, v); chk("R7 nothing taken", v, 0);
    rx_hold = 0;
    send_rx(3, 8'h40);
    rd(A_RXCNT, v); chk("R7 after release", v, 3);
    drain_rx(3, 8'h40, "R7 drain");
  endtask

  task automatic t_rx_long;
    logic [31:0] v;
    send_rx(DEPTH + 4, 8'h01);
    rd(A_RXCNT, v); chk("R13 truncated count", v, DEPTH);
    drain_rx(DEPTH, 8'h01, "R13 drain");
  endtask

  task automatic push_tx(input int cnt_wr, input int len, input int base, input string req);
    logic [31:0] v;
    int d0 = done_n;
    txn = 0;
    wr(A_TXCNT, 32'(cnt_wr));
    rd(A_TXCNT, v); chk({req, " R8 count readback"}, v, 32'(len));
    for (int i = 0; i < len; i++) wr(A_TXP, {24'hABCDEF, pat(base, i)});
    rd(A_TXCNT, v); chk({req, " R9 count cleared"}, v, 0);
    if (bp_mode) begin
      wr(A_TXCNT, 7);
      rd(A_TXCNT, v); chk({req, " R8 write while sending"}, v, 0);
    end
    for (int k = 0; k < 200 && done_n == d0; k++) @(negedge clk);
    @(negedge clk);
    chk({req, " R11 done once"}, 32'(done_n - d0), 1);
    chk({req, " R10 length"}, 32'(txn), 32'(len));
    for (int i = 0; i < len && i < 64; i++) begin
      chk({req, " R10 byte"}, {24'd0, txq[i]}, {24'd0, pat(base, i)});
      chk({req, " R10 last"}, {31'd0, txl[i]}, {31'd0, (i == len - 1)});
    end
  endtask

  task automatic t_tx_stray;
    logic [31:0] v;
    int n0;
    n0 = txn;
    wr(A_TXP, 32'h55);
    repeat (4) @(negedge clk);
    chk("R9 stray write no output", 32'(txn - n0), 0);
    chk("R9 tx_valid idle", {31'd0, tx_valid}, 0);
    rd(A_BUSY, v); chk("R12 busy after tx", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ident();
    t_rx_basic();
    t_rx_hold();
    t_rx_long();
    push_tx(4, 4, 8'h20, "plain");
    t_tx_stray();
    bp_mode = 1;
    push_tx(6, 6, 8'h70, "backpressure");
    bp_mode = 0; tx_ready = 1;
    push_tx(100, DEPTH, 8'h90, "clamped");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule